// File: doc/BRIEF.md
# Local Countdown Timer with Clock Divider

This block is the countdown timer that sits beside each processor's local interrupt logic. Software configures it with register writes. It sets a start count, a divide setting and a timer entry. The entry carries the interrupt vector, a mask flag and a choice between one-shot and periodic operation. The block clock, slowed by a power-of-two prescaler, decrements a live count. When that count runs out, the block sends a one-cycle expiry request to the neighbouring vector-table logic. That logic applies the mask and raises the interrupt.

In periodic mode the count restarts from the start value on every expiry. In one-shot mode the timer goes idle. A level input mirrors the software-enable bit. Dropping it halts the timer at once. Raising it again restarts the countdown only when the entry selects periodic mode. A read port returns the stored settings or the live count.

Top module: `local_timer`

## Requirements
- R1: The divide setting uses only register bits 3, 1 and 0, which form the code {bit3,bit1,bit0}. The codes 000..110 select a divisor of 2, 4, 8, 16, 32, 64 and 128, and code 111 selects 1. A read of the divide register returns only those three bits, and every other bit reads as zero.
- R2: A nonzero write to the start-count register (select 0) loads the counter and starts counting, provided the enable input is high. With start count N and divisor D, the first expiry pulse appears N*D clock cycles after the clock edge that takes the write.
- R3: Writing zero as the start count stops the timer. No expiry follows, and the live count reads 0.
- R4: A divide write made while a countdown is in progress does not change that countdown. The new divisor applies from the next load or periodic reload.
- R5: The live count (select 1) reads the remaining count while the timer runs, never more than the start count, and reads 0 while idle. Writes to select 1 are ignored. Read data is registered and follows the read select by one cycle.
- R6: Timer entry bit 17 selects periodic mode. In that mode every expiry reloads the start count, so pulses repeat every N*D cycles. With bit 17 clear, the timer stops after one expiry and the live count reads 0.
- R7: While the enable input is low, the timer is stopped, gives no expiry and reads a live count of 0. A start-count write made while the enable input is low is stored but does not start the timer. A rising edge of the enable input restarts the countdown from the stored start count only if the entry selects periodic mode and that count is nonzero.
- R8: After reset, the start count and live count read 0, the divide register reads 0 (divisor 2), the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), and no expiry pulse is present.
- R9: Each expiry is a one-cycle pulse. It comes with the entry's vector (bits 7:0) and mask flag (bit 16) on the side outputs, and it is sent even when the entry is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the undivided timer clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en_i | input | 1 | Software enable level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 start count, 1 live count (ignored), 2 divide, 3 timer entry |
| wr_data_i | input | DATA_W | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as the write select |
| rd_data_o | output | DATA_W | Registered read data |
| expire_o | output | 1 | One-cycle expiry request |
| expire_vec_o | output | VEC_W | Vector from the timer entry |
| expire_masked_o | output | 1 | Mask flag from the timer entry |

## Verification
A counter or prescaler that is off by a cycle shows up directly as a wrong interval between pulses, and that interval is measured against N*D from the first period onward. A divisor latched at the wrong moment only shows in the period after a divide write, so the bench times two successive periodic intervals around such a write. A stale run flag shows as a nonzero live count or a stray pulse after a disable or a zero write, and the bench watches for these over a window longer than the configured period.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [1:0] {
    SEL_INIT  = 2'd0,
    SEL_CUR   = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_ENTRY = 2'd3
  } reg_sel_e;

  localparam int SHIFT_W        = 3;
  localparam int PRE_W          = (1 << SHIFT_W) - 1;
  localparam int ENTRY_MASK_BIT = 16;
  localparam int ENTRY_PER_BIT  = 17;
  localparam int DIV_BIT_HI     = 3;
  localparam int DIV_BIT_MID    = 1;
  localparam int DIV_BIT_LO     = 0;

  // divide code {b3,b1,b0} -> log2(divisor); 111 wraps to 0 (divide by 1)
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lct_regs.sv
module lct_regs
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [1:0]          rd_sel_i,
  input  logic                run_i,
  input  logic [DATA_W-1:0]   cur_i,
  output logic                init_wr_o,
  output logic [DATA_W-1:0]   init_q_o,
  output logic [SHIFT_W-1:0]  cfg_shift_o,
  output logic                periodic_o,
  output logic                masked_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam logic [DATA_W-1:0] ENTRY_KEEP =
    DATA_W'((1 << VEC_W) - 1) | (DATA_W'(1) << ENTRY_MASK_BIT) | (DATA_W'(1) << ENTRY_PER_BIT);
  localparam logic [DATA_W-1:0] ENTRY_RST = DATA_W'(1) << ENTRY_MASK_BIT;

  logic [DATA_W-1:0] init_q, entry_q;
  logic [2:0]        div_code_q;
  logic [DATA_W-1:0] div_view;

  assign init_wr_o = wr_en_i && (wr_sel_i == SEL_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q     <= '0;
      div_code_q <= '0;
      entry_q    <= ENTRY_RST;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_INIT:  init_q     <= wr_data_i;
        SEL_DIV:   div_code_q <= {wr_data_i[DIV_BIT_HI], wr_data_i[DIV_BIT_MID], wr_data_i[DIV_BIT_LO]};
        SEL_ENTRY: entry_q    <= wr_data_i & ENTRY_KEEP;
        default:   ;
      endcase
    end
  end

  always_comb begin
    div_view              = '0;
    div_view[DIV_BIT_HI]  = div_code_q[2];
    div_view[DIV_BIT_MID] = div_code_q[1];
    div_view[DIV_BIT_LO]  = div_code_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      case (rd_sel_i)
        SEL_INIT: rd_data_o <= init_q;
        SEL_CUR:  rd_data_o <= run_i ? cur_i : '0;
        SEL_DIV:  rd_data_o <= div_view;
        default:  rd_data_o <= entry_q;
      endcase
    end
  end

  assign init_q_o    = init_q;
  assign cfg_shift_o = div_shift(div_code_q);
  assign periodic_o  = entry_q[ENTRY_PER_BIT];
  assign masked_o    = entry_q[ENTRY_MASK_BIT];
  assign vec_o       = entry_q[VEC_W-1:0];

  // writes to the live-count select leave all settings untouched
  assert_cur_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == SEL_CUR) |=> ($stable(init_q) && $stable(div_code_q) && $stable(entry_q)));
endmodule

// File: rtl/lct_prescale.sv
module lct_prescale
  import lct_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] phase_mask;

  assign phase_mask = PRE_W'((1 << shift_i) - 1);
  assign tick_o     = ((pre_q & phase_mask) == phase_mask);

  always_ff @(posedge clk) begin
    if (rst || restart_i) pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  // a restart aligns the phase: the first tick lands D cycles later
  assert_restart_phase_R2: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (tick_o == (shift_i == '0)));
endmodule

// File: rtl/lct_counter.sv
module lct_counter
  import lct_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_en_i,
  input  logic               init_wr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [DATA_W-1:0]  init_q_i,
  input  logic [SHIFT_W-1:0] cfg_shift_i,
  input  logic               periodic_i,
  input  logic               tick_i,
  output logic               run_o,
  output logic [DATA_W-1:0]  cur_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               restart_o,
  output logic               expire_o
);
  logic               run_q, run_d, en_q, en_rise, exp_q, exp_d;
  logic [DATA_W-1:0]  cur_q, cur_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;

  assign en_rise = sw_en_i && !en_q;

  always_comb begin
    run_d     = run_q;
    cur_d     = cur_q;
    shift_d   = shift_q;
    exp_d     = 1'b0;
    restart_o = 1'b0;
    if (!sw_en_i) begin
      run_d = 1'b0;
      cur_d = '0;
    end else if (init_wr_i) begin
      run_d     = |wr_data_i;
      cur_d     = wr_data_i;
      shift_d   = cfg_shift_i;
      restart_o = 1'b1;
    end else if (en_rise && periodic_i && |init_q_i) begin
      run_d     = 1'b1;
      cur_d     = init_q_i;
      shift_d   = cfg_shift_i;
      restart_o = 1'b1;
    end else if (run_q && tick_i) begin
      if (cur_q == DATA_W'(1)) begin
        exp_d = 1'b1;
        if (periodic_i) begin
          cur_d     = init_q_i;
          shift_d   = cfg_shift_i;
          restart_o = 1'b1;
        end else begin
          run_d = 1'b0;
          cur_d = '0;
        end
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cur_q   <= '0;
      shift_q <= div_shift(3'b000);
      exp_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      run_q   <= run_d;
      cur_q   <= cur_d;
      shift_q <= shift_d;
      exp_q   <= exp_d;
      en_q    <= sw_en_i;
    end
  end

  assign run_o    = run_q;
  assign cur_o    = cur_q;
  assign shift_o  = shift_q;
  assign expire_o = exp_q;

  assert_disable_halts_R7: assert property (@(posedge clk) disable iff (rst)
    !sw_en_i |=> (!run_q && !exp_q));
  assert_zero_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (sw_en_i && init_wr_i && wr_data_i == '0) |=> (!run_q && !exp_q));
  assert_div_held_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && !restart_o) |=> $stable(shift_q));
  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (rst)
    (exp_q && !periodic_i && !restart_o && sw_en_i && !init_wr_i) |-> !run_q);
endmodule

// File: rtl/local_timer.sv
module local_timer
  import lct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              expire_o,
  output logic [VEC_W-1:0]  expire_vec_o,
  output logic              expire_masked_o
);
  logic               init_wr, periodic, run, tick, restart;
  logic [DATA_W-1:0]  init_q, cur;
  logic [SHIFT_W-1:0] cfg_shift, act_shift;

  lct_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .run_i(run), .cur_i(cur), .init_wr_o(init_wr), .init_q_o(init_q),
    .cfg_shift_o(cfg_shift), .periodic_o(periodic), .masked_o(expire_masked_o),
    .vec_o(expire_vec_o), .rd_data_o(rd_data_o)
  );

  lct_prescale u_pre (
    .clk(clk), .rst(rst), .restart_i(restart), .shift_i(act_shift), .tick_o(tick)
  );

  lct_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .sw_en_i(sw_en_i), .init_wr_i(init_wr), .wr_data_i(wr_data_i),
    .init_q_i(init_q), .cfg_shift_i(cfg_shift), .periodic_i(periodic), .tick_i(tick),
    .run_o(run), .cur_o(cur), .shift_o(act_shift), .restart_o(restart), .expire_o(expire_o)
  );

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cur <= init_q && cur != '0));
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !(periodic && init_q == DATA_W'(1) && act_shift == '0)) |=> !expire_o);
endmodule

// File: tb/local_timer_tb.sv
module local_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        expire;
  logic [7:0]  exp_vec;
  logic        exp_masked;

  int checks = 0, errors = 0, cyc = 0, t_wr = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  local_timer u_dut (
    .clk(clk), .rst(rst), .sw_en_i(sw_en), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .expire_o(expire),
    .expire_vec_o(exp_vec), .expire_masked_o(exp_masked)
  );

  function automatic int exp_div(input logic [2:0] code);
    return 1 << ((int'(code) + 1) % 8);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    t_wr = cyc;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_pulse(input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (expire) begin t = cyc; break; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int t, t0, t1;
    void'($urandom(32'h1DEA5));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R8 reset state
    check(expire == 1'b0, "R8 expire", expire, 0);
    rd(2'd0, v); check(v == 0, "R8 start", v, 0);
    rd(2'd1, v); check(v == 0, "R8 live", v, 0);
    rd(2'd2, v); check(v == 0, "R8 divide", v, 0);
    rd(2'd3, v); check(v == 32'h0001_0000, "R8 entry", v, 32'h0001_0000);

    // R1 only bits 3,1,0 kept
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check(v == 32'hB, "R1 readback", v, 32'hB);

    // R2/R6 directed one-shot, default divide 2
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0000_0042);
    wr(2'd0, 5);
    t0 = t_wr;
    wait_pulse(100, t); check(t - t0 == 10, "R2 first expiry", t - t0, 10);
    check(exp_vec == 8'h42 && !exp_masked, "R9 vector", exp_vec, 8'h42);
    wait_pulse(40, t); check(t == -1, "R6 one-shot no repeat", t, -1);
    rd(2'd1, v); check(v == 0, "R6 idle read", v, 0);

    // R1/R2/R6/R9 random
    for (int it = 0; it < 10; it++) begin
      logic [2:0] code;
      int n, d, per, msk;
      logic [7:0] vec;
      code = 3'($urandom_range(0, 7));
      n    = $urandom_range(1, 10);
      per  = $urandom_range(0, 1);
      msk  = $urandom_range(0, 1);
      vec  = 8'($urandom_range(0, 255));
      d    = exp_div(code);
      wr(2'd2, ($urandom & ~32'hB) | {28'd0, code[2], 1'b0, code[1:0]});
      wr(2'd3, {14'd0, per[0], msk[0], 8'd0, vec});
      wr(2'd0, n);
      t0 = t_wr;
      wait_pulse(n * d + 20, t);
      check(t - t0 == n * d, "R1 period", t - t0, n * d);
      check(exp_vec == vec && exp_masked == msk[0], "R9 side data", {exp_masked, exp_vec}, {msk[0], vec});
      if (per != 0) begin
        t1 = t;
        if (n * d > 1) begin
          @(negedge clk); check(expire == 1'b0, "R9 one cycle", expire, 0);
        end
        wait_pulse(n * d + 20, t);
        check(t - t1 == n * d, "R6 periodic reload", t - t1, n * d);
      end else begin
        wait_pulse(n * d + 5, t);
        check(t == -1, "R6 one-shot stop", t, -1);
      end
      wr(2'd0, 0);
    end

    // R4 divide change mid countdown
    wr(2'd2, 32'h1);
    wr(2'd3, 32'h0002_0010);
    wr(2'd0, 6);
    t0 = t_wr;
    wr(2'd2, 32'h0);
    wait_pulse(100, t); check(t - t0 == 24, "R4 old divisor", t - t0, 24);
    t1 = t;
    wait_pulse(100, t); check(t - t1 == 12, "R4 new divisor", t - t1, 12);

    // R3 zero start count stops
    wr(2'd0, 0);
    wait_pulse(300, t); check(t == -1, "R3 no expiry", t, -1);
    rd(2'd1, v); check(v == 0, "R3 live zero", v, 0);

    // R5 live count read and ignored write
    wr(2'd3, 32'h0);
    wr(2'd2, 32'hA);
    wr(2'd0, 100);
    t0 = t_wr;
    rd(2'd1, v); check(v == 100, "R5 live count", v, 100);
    wr(2'd1, 5);
    rd(2'd1, v); check(v == 100, "R5 write ignored", v, 100);
    wait_pulse(13000, t); check(t - t0 == 12800, "R5 timing kept", t - t0, 12800);
    rd(2'd1, v); check(v == 0, "R5 idle read", v, 0);

    // R7 enable handling, periodic
    wr(2'd2, 32'hB);
    wr(2'd3, 32'h0002_0020);
    wr(2'd0, 3);
    wait_pulse(20, t); check(t - t_wr == 3, "R7 running", t - t_wr, 3);
    @(negedge clk) sw_en = 1'b0;
    wait_pulse(50, t); check(t == -1, "R7 halted", t, -1);
    rd(2'd1, v); check(v == 0, "R7 halted read", v, 0);
    @(negedge clk) sw_en = 1'b1;
    @(posedge clk); @(negedge clk); t0 = cyc;
    wait_pulse(20, t); check(t - t0 == 3, "R7 periodic restart", t - t0, 3);

    // R7 one-shot: no restart, and a write while disabled does not start
    wr(2'd3, 32'h0001_0020);
    wr(2'd0, 3);
    wait_pulse(20, t);
    @(negedge clk) sw_en = 1'b0;
    wr(2'd0, 4);
    @(negedge clk) sw_en = 1'b1;
    wait_pulse(50, t); check(t == -1, "R7 one-shot stays idle", t, -1);
    rd(2'd1, v); check(v == 0, "R7 idle read", v, 0);
    rd(2'd0, v); check(v == 4, "R7 stored start", v, 4);

    finish_run();
  end
endmodule